// File: doc/BRIEF.md
# Stream iteration map with speculative-step recovery

This block sits beside the dispatch stage of an out-of-order core that reads memory through configured streams. Each stream is named by a small id. For each stream the block keeps a speculative iteration counter and a committed iteration counter. An instruction that reads a stream's data register is looked up at dispatch and tagged with the element index it must read. A step instruction advances the speculative counter. Because element fetch is decoupled from use, recovery from a wrongly predicted step needs only a decrement. The stream's element buffer is neither flushed nor refetched.

Every cycle can carry one configure event, one end event, one commit of a step, one squash of a number of steps, and several dispatch slots. Each slot is either a lookup or a step. For a general flush the block holds one snapshot of all counters and validity bits. The snapshot is taken on request and restored on flush. A lookup to a stream that is not configured returns an error flag, so a fault is only reported when an instruction actually uses the element. Lookup results are registered and appear one cycle after dispatch.

Top module: `stream_iter_map`

## Requirements
- R1: While reset is high and in the first cycle after it, every lookup output is zero and no stream is configured.
- R2: A configure event makes the stream valid with both counters at 0. A lookup in the same cycle already sees iteration 0.
- R3: Each dispatched step slot (disp_step=1) to a valid stream raises its speculative counter by one. A later lookup returns the raised value.
- R4: Within one cycle, slots are taken in program order by index. A lookup in slot k returns the counter plus the number of step slots below k that name the same stream. Steps in higher slots do not affect it.
- R5: A squash event lowers the named stream's speculative counter by squash_cnt. Lookups in the same cycle see the lowered value.
- R6: A commit event raises the committed counter by one. A squash never takes the speculative counter below the committed counter, including one committed in the same cycle.
- R7: An end event invalidates the stream. A lookup to an invalid stream returns look_err=1 with look_iter=0. Steps to an invalid stream have no effect.
- R8: ckpt_take stores all speculative counters and validity bits. flush_restore brings them back, and it discards the configure, end, squash and dispatch inputs of that cycle, so no look_valid follows.
- R9: A restored counter is never below the committed counter of that stream, including commits after the snapshot.
- R10: Configure, end and squash of a cycle take effect before that cycle's lookups. Results appear on the look_* outputs exactly one cycle after dispatch.
- R11: Events that name one stream leave the counters of every other stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configure event |
| cfg_id | input | ID_W | Stream configured |
| end_valid | input | 1 | End event |
| end_id | input | ID_W | Stream ended |
| disp_valid | input | SLOTS | Dispatch slot valid, bit per slot |
| disp_step | input | SLOTS | 1 = step, 0 = lookup, bit per slot |
| disp_id | input | SLOTS*ID_W | Stream id per slot, slot k at bits k*ID_W |
| commit_valid | input | 1 | Step commit event |
| commit_id | input | ID_W | Stream whose step commits |
| squash_valid | input | 1 | Squash of speculated steps |
| squash_id | input | ID_W | Stream squashed |
| squash_cnt | input | SQ_W | Number of steps undone |
| ckpt_take | input | 1 | Store snapshot of all counters |
| flush_restore | input | 1 | Restore snapshot, drop cycle's other inputs |
| look_valid | output | SLOTS | Registered lookup result valid per slot |
| look_iter | output | SLOTS*ITER_W | Iteration tag per slot |
| look_err | output | SLOTS | Lookup hit an invalid stream |

## Verification
A wrong counter is not visible when it goes wrong. It shows only at the next lookup to that stream, one cycle after that lookup is dispatched, as an iteration tag that is off by the size of the error. A bad validity bit shows the same way, as a wrong look_err. The bench therefore follows every event with lookups. It also mixes steps and lookups to the same stream in one cycle, so that the ordering by slot is seen at once. Squash floors and restores are placed after commits, so a missing floor shows up as a tag below the committed count.

// File: rtl/stream_iter_pkg.sv
package stream_iter_pkg;
  // Kind of work carried by one dispatch slot.
  typedef enum logic {
    SLOT_USE  = 1'b0,
    SLOT_STEP = 1'b1
  } slot_kind_e;

  // Larger of two unsigned values of equal width.
  function automatic logic [31:0] umax32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? b : a;
  endfunction
endpackage

// File: rtl/iter_slot_decode.sv
module iter_slot_decode #(
  parameter int NUM_STREAMS = 4,
  parameter int SLOTS       = 2,
  parameter int ID_W        = 2,
  parameter int STEP_W      = 2
) (
  input  logic [SLOTS-1:0]             slot_vld,
  input  logic [SLOTS-1:0]             slot_step,
  input  logic [SLOTS*ID_W-1:0]        slot_id,
  output logic [NUM_STREAMS*STEP_W-1:0] step_cnt,
  output logic [SLOTS*STEP_W-1:0]      slot_off
);
  import stream_iter_pkg::*;

  // Total steps per stream in this cycle.
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_cnt
    logic [STEP_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < SLOTS; k++) begin
        if (slot_vld[k] && (slot_kind_e'(slot_step[k]) == SLOT_STEP) &&
            (slot_id[k*ID_W +: ID_W] == ID_W'(s)))
          acc = acc + STEP_W'(1);
      end
      step_cnt[s*STEP_W +: STEP_W] = acc;
    end
  end

  // Steps in older slots that name the same stream as slot k.
  for (genvar k = 0; k < SLOTS; k++) begin : g_off
    logic [STEP_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < k; j++) begin
        if (slot_vld[j] && (slot_kind_e'(slot_step[j]) == SLOT_STEP) &&
            (slot_id[j*ID_W +: ID_W] == slot_id[k*ID_W +: ID_W]))
          acc = acc + STEP_W'(1);
      end
      slot_off[k*STEP_W +: STEP_W] = acc;
    end
  end
endmodule

// File: rtl/iter_lane.sv
module iter_lane #(
  parameter int ITER_W = 8,
  parameter int STEP_W = 2,
  parameter int SQ_W   = 2
) (
  input  logic [ITER_W-1:0] cur_spec,
  input  logic [ITER_W-1:0] cur_cmt,
  input  logic              cur_vld,
  input  logic [ITER_W-1:0] ckpt_spec,
  input  logic              ckpt_vld,
  input  logic              restore,
  input  logic              cfg_hit,
  input  logic              end_hit,
  input  logic              sq_hit,
  input  logic [SQ_W-1:0]   sq_cnt,
  input  logic              cmt_hit,
  input  logic [STEP_W-1:0] step_cnt,
  output logic [ITER_W-1:0] base_spec,
  output logic              base_vld,
  output logic [ITER_W-1:0] nxt_spec,
  output logic [ITER_W-1:0] nxt_cmt,
  output logic              nxt_vld
);
  logic [ITER_W-1:0] cmt_now;
  logic [ITER_W-1:0] headroom;
  logic [ITER_W-1:0] sq_ext;

  always_comb begin
    // Committed count including this cycle's commit; a fresh configure clears it.
    cmt_now  = (cfg_hit && !restore) ? '0 : cur_cmt + ITER_W'(cmt_hit);
    headroom = cur_spec - cmt_now;
    sq_ext   = ITER_W'(sq_cnt);

    // State seen by this cycle's lookups: configure, end and squash first.
    if (cfg_hit) begin
      base_vld  = 1'b1;
      base_spec = '0;
    end else begin
      base_vld = end_hit ? 1'b0 : cur_vld;
      if (sq_hit)
        base_spec = (headroom < sq_ext) ? cmt_now : cur_spec - sq_ext;
      else
        base_spec = cur_spec;
    end

    nxt_cmt = cmt_now;
    if (restore) begin
      nxt_vld  = ckpt_vld;
      nxt_spec = (ckpt_spec < cmt_now) ? cmt_now : ckpt_spec;
    end else begin
      nxt_vld  = base_vld;
      nxt_spec = base_vld ? base_spec + ITER_W'(step_cnt) : base_spec;
    end
  end
endmodule

// File: rtl/iter_lookup.sv
module iter_lookup #(
  parameter int NUM_STREAMS = 4,
  parameter int SLOTS       = 2,
  parameter int ID_W        = 2,
  parameter int ITER_W      = 8,
  parameter int STEP_W      = 2
) (
  input  logic [NUM_STREAMS*ITER_W-1:0] base_spec,
  input  logic [NUM_STREAMS-1:0]        base_vld,
  input  logic [SLOTS*ID_W-1:0]         slot_id,
  input  logic [SLOTS*STEP_W-1:0]       slot_off,
  output logic [SLOTS*ITER_W-1:0]       hit_iter,
  output logic [SLOTS-1:0]              hit_err
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [ID_W-1:0]   sid;
    logic [ITER_W-1:0] sel;
    always_comb begin
      sid = slot_id[k*ID_W +: ID_W];
      sel = base_spec[sid*ITER_W +: ITER_W];
      if (base_vld[sid]) begin
        hit_err[k]                   = 1'b0;
        hit_iter[k*ITER_W +: ITER_W] = sel + ITER_W'(slot_off[k*STEP_W +: STEP_W]);
      end else begin
        hit_err[k]                   = 1'b1;
        hit_iter[k*ITER_W +: ITER_W] = '0;
      end
    end
  end
endmodule

// File: rtl/stream_iter_map.sv
module stream_iter_map #(
  parameter int NUM_STREAMS = 4,
  parameter int SLOTS       = 2,
  parameter int ITER_W      = 8,
  parameter int SQ_W        = 2,
  localparam int ID_W       = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int STEP_W     = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_valid,
  input  logic [ID_W-1:0]         cfg_id,
  input  logic                    end_valid,
  input  logic [ID_W-1:0]         end_id,
  input  logic [SLOTS-1:0]        disp_valid,
  input  logic [SLOTS-1:0]        disp_step,
  input  logic [SLOTS*ID_W-1:0]   disp_id,
  input  logic                    commit_valid,
  input  logic [ID_W-1:0]         commit_id,
  input  logic                    squash_valid,
  input  logic [ID_W-1:0]         squash_id,
  input  logic [SQ_W-1:0]         squash_cnt,
  input  logic                    ckpt_take,
  input  logic                    flush_restore,
  output logic [SLOTS-1:0]        look_valid,
  output logic [SLOTS*ITER_W-1:0] look_iter,
  output logic [SLOTS-1:0]        look_err
);
  logic [NUM_STREAMS*ITER_W-1:0] spec_q, cmt_q, ckpt_spec_q;
  logic [NUM_STREAMS-1:0]        vld_q, ckpt_vld_q;
  logic [NUM_STREAMS*ITER_W-1:0] spec_d, cmt_d, base_spec;
  logic [NUM_STREAMS-1:0]        vld_d, base_vld;
  logic [NUM_STREAMS*STEP_W-1:0] step_cnt;
  logic [SLOTS*STEP_W-1:0]       slot_off;
  logic [SLOTS*ITER_W-1:0]       hit_iter;
  logic [SLOTS-1:0]              hit_err;
  logic [SLOTS-1:0]              live_slot;
  logic [SLOTS-1:0]              use_slot;

  // A flush cancels every dispatch slot of its cycle.
  assign live_slot = disp_valid & {SLOTS{~flush_restore}};
  assign use_slot  = live_slot & ~disp_step;

  iter_slot_decode #(
    .NUM_STREAMS(NUM_STREAMS), .SLOTS(SLOTS), .ID_W(ID_W), .STEP_W(STEP_W)
  ) i_decode (
    .slot_vld (live_slot),
    .slot_step(disp_step),
    .slot_id  (disp_id),
    .step_cnt (step_cnt),
    .slot_off (slot_off)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
    iter_lane #(.ITER_W(ITER_W), .STEP_W(STEP_W), .SQ_W(SQ_W)) i_lane (
      .cur_spec (spec_q[s*ITER_W +: ITER_W]),
      .cur_cmt  (cmt_q[s*ITER_W +: ITER_W]),
      .cur_vld  (vld_q[s]),
      .ckpt_spec(ckpt_spec_q[s*ITER_W +: ITER_W]),
      .ckpt_vld (ckpt_vld_q[s]),
      .restore  (flush_restore),
      .cfg_hit  (cfg_valid && (cfg_id == ID_W'(s))),
      .end_hit  (end_valid && (end_id == ID_W'(s))),
      .sq_hit   (squash_valid && (squash_id == ID_W'(s))),
      .sq_cnt   (squash_cnt),
      .cmt_hit  (commit_valid && (commit_id == ID_W'(s))),
      .step_cnt (step_cnt[s*STEP_W +: STEP_W]),
      .base_spec(base_spec[s*ITER_W +: ITER_W]),
      .base_vld (base_vld[s]),
      .nxt_spec (spec_d[s*ITER_W +: ITER_W]),
      .nxt_cmt  (cmt_d[s*ITER_W +: ITER_W]),
      .nxt_vld  (vld_d[s])
    );
  end

  iter_lookup #(
    .NUM_STREAMS(NUM_STREAMS), .SLOTS(SLOTS), .ID_W(ID_W),
    .ITER_W(ITER_W), .STEP_W(STEP_W)
  ) i_lookup (
    .base_spec(base_spec),
    .base_vld (base_vld),
    .slot_id  (disp_id),
    .slot_off (slot_off),
    .hit_iter (hit_iter),
    .hit_err  (hit_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_q      <= '0;
      cmt_q       <= '0;
      vld_q       <= '0;
      ckpt_spec_q <= '0;
      ckpt_vld_q  <= '0;
    end else begin
      spec_q <= spec_d;
      cmt_q  <= cmt_d;
      vld_q  <= vld_d;
      if (ckpt_take) begin
        ckpt_spec_q <= spec_q;
        ckpt_vld_q  <= vld_q;
      end
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        look_valid[k]                 <= 1'b0;
        look_err[k]                   <= 1'b0;
        look_iter[k*ITER_W +: ITER_W] <= '0;
      end else begin
        look_valid[k]                 <= use_slot[k];
        look_err[k]                   <= use_slot[k] & hit_err[k];
        look_iter[k*ITER_W +: ITER_W] <= use_slot[k] ? hit_iter[k*ITER_W +: ITER_W] : '0;
      end
    end
  end
endmodule

// File: rtl/iter_map_checker.sv
module iter_map_checker #(
  parameter int SLOTS  = 2,
  parameter int ITER_W = 8,
  parameter int ID_W   = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_valid,
  input logic [ID_W-1:0]         cfg_id,
  input logic [SLOTS-1:0]        disp_valid,
  input logic [SLOTS-1:0]        disp_step,
  input logic [SLOTS*ID_W-1:0]   disp_id,
  input logic                    flush_restore,
  input logic [SLOTS-1:0]        look_valid,
  input logic [SLOTS*ITER_W-1:0] look_iter,
  input logic [SLOTS-1:0]        look_err
);
  // R1: nothing comes out in the cycle after reset.
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> (look_valid == '0 && look_err == '0));

  // R8: a flush drops the lookups of its cycle.
  assert_flush_drops_R8: assert property (@(posedge clk) disable iff (rst)
    flush_restore |=> (look_valid == '0));

  // R10: each lookup slot yields a result exactly one cycle later.
  assert_one_cycle_latency_R10: assert property (@(posedge clk) disable iff (rst)
    !flush_restore |=> (look_valid == $past(disp_valid & ~disp_step)));

  // R7: an error flag only accompanies a live result.
  assert_err_qualified_R7: assert property (@(posedge clk) disable iff (rst)
    ((look_err & ~look_valid) == '0));

  // R2: a lookup in slot 0 alongside a configure of its stream reads 0.
  assert_cfg_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !flush_restore && disp_valid[0] && !disp_step[0] &&
     disp_id[ID_W-1:0] == cfg_id)
    |=> (look_valid[0] && !look_err[0] && look_iter[ITER_W-1:0] == '0));

  if (SLOTS >= 2) begin : g_pair
    // R4: two lookups of one stream with no step between them agree.
    assert_same_cycle_uses_R4: assert property (@(posedge clk) disable iff (rst)
      (!flush_restore && disp_valid[1:0] == 2'b11 && disp_step[1:0] == 2'b00 &&
       disp_id[ID_W-1:0] == disp_id[2*ID_W-1:ID_W])
      |=> (look_iter[ITER_W-1:0] == look_iter[2*ITER_W-1:ITER_W] &&
           look_err[0] == look_err[1]));
  end
endmodule

bind stream_iter_map iter_map_checker #(
  .SLOTS(SLOTS), .ITER_W(ITER_W), .ID_W(ID_W)
) i_iter_map_checker (
  .clk          (clk),
  .rst          (rst),
  .cfg_valid    (cfg_valid),
  .cfg_id       (cfg_id),
  .disp_valid   (disp_valid),
  .disp_step    (disp_step),
  .disp_id      (disp_id),
  .flush_restore(flush_restore),
  .look_valid   (look_valid),
  .look_iter    (look_iter),
  .look_err     (look_err)
);

// File: tb/test_stream_iter_map.sv
module test_stream_iter_map;
  localparam int NS = 4, SL = 2, IW = 8, QW = 2, IDW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_valid, end_valid, commit_valid, squash_valid, ckpt_take, flush_restore;
  logic [IDW-1:0] cfg_id, end_id, commit_id, squash_id;
  logic [QW-1:0]  squash_cnt;
  logic [SL-1:0]  disp_valid, disp_step;
  logic [SL*IDW-1:0] disp_id;
  logic [SL-1:0]  look_valid, look_err;
  logic [SL*IW-1:0] look_iter;

  always #5 clk = ~clk;

  stream_iter_map #(.NUM_STREAMS(NS), .SLOTS(SL), .ITER_W(IW), .SQ_W(QW)) i_stream_iter_map (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_id(cfg_id),
    .end_valid(end_valid), .end_id(end_id), .disp_valid(disp_valid),
    .disp_step(disp_step), .disp_id(disp_id), .commit_valid(commit_valid),
    .commit_id(commit_id), .squash_valid(squash_valid), .squash_id(squash_id),
    .squash_cnt(squash_cnt), .ckpt_take(ckpt_take), .flush_restore(flush_restore),
    .look_valid(look_valid), .look_iter(look_iter), .look_err(look_err));

  // Reference state built from the requirements.
  logic [IW-1:0] m_spec [NS];
  logic [IW-1:0] m_cmt  [NS];
  logic          m_vld  [NS];
  logic [IW-1:0] c_spec [NS];
  logic          c_vld  [NS];
  logic [SL-1:0] e_valid, e_err;
  logic [IW-1:0] e_iter [SL];
  string e_tag = "R1";
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic report(input string tag, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    report(e_tag, int'(look_valid), int'(e_valid), "look_valid");
    for (int k = 0; k < SL; k++) begin
      if (e_valid[k]) begin
        report(e_tag, int'(look_err[k]), int'(e_err[k]), "look_err");
        report(e_tag, int'(look_iter[k*IW +: IW]), int'(e_iter[k]), "look_iter");
      end
    end
  endtask

  task automatic clear_in();
    cfg_valid = 0; cfg_id = 0; end_valid = 0; end_id = 0;
    commit_valid = 0; commit_id = 0; squash_valid = 0; squash_id = 0; squash_cnt = 0;
    ckpt_take = 0; flush_restore = 0; disp_valid = 0; disp_step = 0; disp_id = 0;
  endtask

  task automatic slot(input int k, input bit is_step, input int id);
    disp_valid[k] = 1'b1;
    disp_step[k]  = is_step;
    disp_id[k*IDW +: IDW] = IDW'(id);
  endtask

  // Compute expected results for the inputs now on the pins and advance the model.
  task automatic model();
    logic [IW-1:0] b_spec [NS];
    logic          b_vld  [NS];
    logic [IW-1:0] cb;
    for (int s = 0; s < NS; s++) begin
      bit inc = commit_valid && commit_id == IDW'(s);
      bit cf  = cfg_valid && cfg_id == IDW'(s) && !flush_restore;
      cb = cf ? '0 : m_cmt[s] + IW'(inc);
      if (cf) begin b_vld[s] = 1; b_spec[s] = 0; end
      else begin
        b_vld[s] = (end_valid && end_id == IDW'(s)) ? 1'b0 : m_vld[s];
        b_spec[s] = m_spec[s];
        if (squash_valid && squash_id == IDW'(s))
          b_spec[s] = (int'(m_spec[s]) - int'(squash_cnt) < int'(cb)) ? cb : m_spec[s] - IW'(squash_cnt);
      end
      m_cmt[s] = cb;
    end
    for (int k = 0; k < SL; k++) begin
      int id = int'(disp_id[k*IDW +: IDW]);
      int off = 0;
      for (int j = 0; j < k; j++)
        if (disp_valid[j] && disp_step[j] && disp_id[j*IDW +: IDW] == IDW'(id)) off++;
      e_valid[k] = !flush_restore && disp_valid[k] && !disp_step[k];
      e_err[k]   = !b_vld[id];
      e_iter[k]  = b_vld[id] ? b_spec[id] + IW'(off) : '0;
    end
    for (int s = 0; s < NS; s++) begin
      logic [IW-1:0] os = m_spec[s];
      bit ov = m_vld[s];
      if (flush_restore) begin
        m_vld[s]  = c_vld[s];
        m_spec[s] = (c_spec[s] < m_cmt[s]) ? m_cmt[s] : c_spec[s];
      end else begin
        int n = 0;
        for (int k = 0; k < SL; k++)
          if (disp_valid[k] && disp_step[k] && disp_id[k*IDW +: IDW] == IDW'(s)) n++;
        m_vld[s]  = b_vld[s];
        m_spec[s] = b_vld[s] ? b_spec[s] + IW'(n) : b_spec[s];
      end
      if (ckpt_take) begin c_spec[s] = os; c_vld[s] = ov; end
    end
  endtask

  // Check the previous cycle's results, then let the current inputs take effect.
  task automatic cyc(input string tag);
    model();
    @(negedge clk);
    e_tag = tag;
    compare();
    clear_in();
  endtask

  initial begin
    clear_in();
    for (int s = 0; s < NS; s++) begin
      m_spec[s] = 0; m_cmt[s] = 0; m_vld[s] = 0; c_spec[s] = 0; c_vld[s] = 0;
    end
    e_valid = 0; e_err = 0;
    for (int k = 0; k < SL; k++) e_iter[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    report("R1", int'(look_valid), 0, "look_valid after reset");
    report("R1", int'(look_iter), 0, "look_iter after reset");
    // R7: lookup before any configure reports an error.
    slot(0, 0, 1); cyc("R7");
    cyc("R7");
    // R2: configure with a lookup in the same cycle.
    cfg_valid = 1; cfg_id = 0; slot(0, 0, 0); cyc("R2");
    cfg_valid = 1; cfg_id = 1; cyc("R2");
    cyc("R2");
    // R3: steps raise the counter.
    slot(0, 1, 0); slot(1, 1, 0); cyc("R3");
    slot(0, 1, 0); cyc("R3");
    slot(0, 0, 0); cyc("R3");
    // R4: order inside one cycle.
    slot(0, 1, 0); slot(1, 0, 0); cyc("R4");
    slot(0, 0, 0); slot(1, 1, 0); cyc("R4");
    slot(0, 0, 0); slot(1, 0, 0); cyc("R4");
    // R11: steps on stream 1 leave stream 0 alone.
    slot(0, 1, 1); slot(1, 1, 1); cyc("R11");
    slot(0, 0, 0); slot(1, 0, 1); cyc("R11");
    // R5: squash with same-cycle lookup.
    squash_valid = 1; squash_id = 0; squash_cnt = 2; slot(0, 0, 0); cyc("R5");
    slot(0, 0, 0); cyc("R5");
    // R6: commits then an oversized squash clamps at the committed count.
    commit_valid = 1; commit_id = 0; cyc("R6");
    commit_valid = 1; commit_id = 0; cyc("R6");
    commit_valid = 1; commit_id = 0; squash_valid = 1; squash_id = 0; squash_cnt = 3;
    slot(0, 0, 0); cyc("R6");
    slot(0, 0, 0); cyc("R6");
    // R8: snapshot, advance, restore with a dropped dispatch.
    ckpt_take = 1; cyc("R8");
    slot(0, 1, 0); slot(1, 1, 1); cyc("R8");
    end_valid = 1; end_id = 1; cyc("R8");
    flush_restore = 1; slot(0, 0, 0); slot(1, 1, 0); cfg_valid = 1; cfg_id = 2; cyc("R8");
    slot(0, 0, 0); slot(1, 0, 1); cyc("R8");
    slot(0, 0, 2); cyc("R8");
    // R9: commits beyond the snapshot hold up the restored value.
    ckpt_take = 1; cyc("R9");
    slot(0, 1, 0); slot(1, 1, 0); cyc("R9");
    commit_valid = 1; commit_id = 0; cyc("R9");
    commit_valid = 1; commit_id = 0; cyc("R9");
    flush_restore = 1; cyc("R9");
    slot(0, 0, 0); cyc("R9");
    // R7: end invalidates and later steps are ignored.
    end_valid = 1; end_id = 0; slot(0, 1, 0); slot(1, 0, 0); cyc("R7");
    slot(0, 1, 0); cyc("R7");
    cfg_valid = 1; cfg_id = 0; cyc("R7");
    slot(0, 0, 0); cyc("R7");
    // R10: random traffic, ordering and latency.
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(7) == 0) begin cfg_valid = 1; cfg_id = IDW'($urandom_range(NS-1)); end
      if ($urandom_range(15) == 0) begin end_valid = 1; end_id = IDW'($urandom_range(NS-1)); end
      if ($urandom_range(7) == 0) begin
        squash_valid = 1; squash_id = IDW'($urandom_range(NS-1)); squash_cnt = QW'($urandom_range(3));
      end
      begin
        int cid = $urandom_range(NS-1);
        if ($urandom_range(2) == 0 && m_vld[cid] && m_cmt[cid] < m_spec[cid] &&
            !(cfg_valid && cfg_id == IDW'(cid))) begin
          commit_valid = 1; commit_id = IDW'(cid);
        end
      end
      if ($urandom_range(15) == 0) ckpt_take = 1;
      if ($urandom_range(31) == 0) flush_restore = 1;
      for (int k = 0; k < SL; k++) begin
        int id = $urandom_range(NS-1);
        if ($urandom_range(3) != 0) slot(k, (m_spec[id] < 200) && ($urandom_range(1) == 1), id);
      end
      cyc("R10");
    end
    cyc("R10");
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule